// File: doc/BRIEF.md
# Powers-of-two segment address encoder

This block turns the upper bits of an operand into the index of the segment that holds it. The segments double in size when moving away from the low end of the interval, halve again toward the high end, or do only one of the two. It is meant to sit in front of a coefficient table in a function-approximation datapath. The table and the polynomial evaluation are outside this block. The index comes from two prefix chains that both start at the most significant bit. One chain ORs the bits and the other ANDs them, and an adder counts the ones on the taps of both chains. No priority encoder is used.

A parameter `MODE` picks one of three variants:
- `FINE_BOTH`: both chains are used, giving 2V segments.
- `FINE_HIGH`: only the AND chain is used. Segments are finest near the all-ones code.
- `FINE_LOW`: only the OR chain is used. Segments are finest near the all-zeros code.

The interface is valid/ready on both sides. With `REG_OUT = 0` the block is pure logic: `out_valid` follows `in_valid` and `in_ready` follows `out_ready` in the same cycle. With `REG_OUT = 1` a one-entry output register breaks the critical path. Its rules are:
- A code is taken when `in_valid && in_ready`.
- `in_ready` is high when the register is empty or is being drained in the same cycle.
- While `out_valid` is high and `out_ready` is low, the output holds still.

Top module: `seg_p2s_encoder`

## Requirements
- R1: With `MODE = FINE_BOTH`, a code whose MSB is 0 and which has z leading zeros maps to index V − z. A code whose MSB is 1 and which has k leading ones maps to index V + k − 1. This gives indices 0 to 2V−1.
- R2: For V = 5 in `FINE_BOTH`, the mapping is as follows (x means don't care):

| Code | Index |
|---|---|
| 00000 | 0 |
| 00001 | 1 |
| 0001x | 2 |
| 001xx | 3 |
| 01xxx | 4 |
| 10xxx | 5 |
| 110xx | 6 |
| 1110x | 7 |
| 11110 | 8 |
| 11111 | 9 |

- R3: With `MODE = FINE_HIGH`, the index equals the number of leading ones of the code, from 0 to V.
- R4: With `MODE = FINE_LOW`, the index equals V minus the number of leading zeros of the code, from 0 to V.
- R5: `out_idx` is ceil(log2(2V)) bits wide, which is 4 bits for V = 5. It never exceeds the largest index of the selected mode while `out_valid` is high.
- R6: With `REG_OUT = 0`, in the same cycle `out_valid` equals `in_valid`, `in_ready` equals `out_ready`, and `out_idx` is the index of `in_code`.
- R7: With `REG_OUT = 1`, a code accepted at a clock edge appears on `out_idx` with `out_valid` high right after that edge.
- R8: With `REG_OUT = 1`, while `out_valid` is high and `out_ready` is low:
  - `out_idx` and `out_valid` hold.
  - `in_ready` is low.
  - A code presented meanwhile is not taken.
- R9: After reset, `out_valid` is low.
- R10: With `REG_OUT = 1` and `out_ready` held high, one code is taken every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream offers a code |
| in_ready | output | 1 | Block accepts the offered code |
| in_code | input | V | Upper operand bits to classify |
| out_valid | output | 1 | Index on `out_idx` is valid |
| out_ready | input | 1 | Downstream takes the index |
| out_idx | output | ceil(log2(2V)) | Segment index |

## Verification
The hardest case to reach from the ports is a stalled output register while a different code waits upstream. The bench has to show that the pending code is neither taken nor allowed to disturb the held index. After that, releasing the stall must drain the old index and load the new code in the same edge. The bench gets there by loading one code with `out_ready` low. It then presents a second code for several stalled cycles, checking that the index holds and `in_ready` stays low. Finally it raises `out_ready` and checks that the second index follows on the next cycle. All 32 codes are also swept back to back through the registered instance and through one unregistered instance per mode.

// File: rtl/seg_p2s_pkg.sv
package seg_p2s_pkg;

  // Which side(s) of the interval get geometrically finer segments.
  typedef enum logic [1:0] {
    FINE_BOTH = 2'd0,  // OR chain + AND chain
    FINE_HIGH = 2'd1,  // AND chain only: counts leading ones
    FINE_LOW  = 2'd2   // OR chain only: V minus leading zeros
  } seg_mode_e;

  typedef enum logic {
    CASC_OR  = 1'b0,
    CASC_AND = 1'b1
  } casc_op_e;

  // Index width for a V-bit field: enough for 2V distinct indices.
  function automatic int idx_width(input int v);
    return (v < 1) ? 1 : $clog2(2 * v);
  endfunction

endpackage

// File: rtl/seg_prefix_chain.sv
// Prefix chain from the MSB downward. Tap k combines code[W-1 : W-1-SKIP-k].
module seg_prefix_chain #(
  parameter int                   W    = 5,
  parameter int                   TAPS = 5,
  parameter int                   SKIP = 0,
  parameter seg_p2s_pkg::casc_op_e OP  = seg_p2s_pkg::CASC_OR
) (
  input  logic [W-1:0]    code,
  output logic [TAPS-1:0] taps
);
  localparam int LAST = TAPS + SKIP - 1;

  logic [LAST:0] chain;

  assign chain[0] = code[W-1];

  for (genvar i = 1; i <= LAST; i++) begin : g_link
    if (OP == seg_p2s_pkg::CASC_OR) begin : g_or
      assign chain[i] = chain[i-1] | code[W-1-i];
    end else begin : g_and
      assign chain[i] = chain[i-1] & code[W-1-i];
    end
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    assign taps[k] = chain[k+SKIP];
  end

  if (SKIP > 0) begin : g_skip_unused
    logic unused_head;
    assign unused_head = ^chain[SKIP-1:0];
  end
endmodule

// File: rtl/seg_ones_count.sv
// Adds up the ones of a tap vector.
module seg_ones_count #(
  parameter int W  = 9,
  parameter int OW = 4
) (
  input  logic [W-1:0]  bits,
  output logic [OW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < W; i++) begin
      count = count + OW'(bits[i]);
    end
  end
endmodule

// File: rtl/seg_index_core.sv
// Combinational code-to-index mapping. The variant is picked by MODE.
module seg_index_core #(
  parameter int                    V    = 5,
  parameter seg_p2s_pkg::seg_mode_e MODE = seg_p2s_pkg::FINE_BOTH,
  parameter int                    IDXW = seg_p2s_pkg::idx_width(V)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [V-1:0]    code,
  output logic [IDXW-1:0] idx
);
  if (MODE == seg_p2s_pkg::FINE_BOTH) begin : g_both
    logic [V-1:0] or_taps;
    logic [V-2:0] and_taps;

    seg_prefix_chain #(.W(V), .TAPS(V), .SKIP(0), .OP(seg_p2s_pkg::CASC_OR))
      u_or (.code(code), .taps(or_taps));
    seg_prefix_chain #(.W(V), .TAPS(V-1), .SKIP(1), .OP(seg_p2s_pkg::CASC_AND))
      u_and (.code(code), .taps(and_taps));
    seg_ones_count #(.W(2*V-1), .OW(IDXW))
      u_cnt (.bits({and_taps, or_taps}), .count(idx));

    // R1: any set AND tap means the MSB is set, so the whole OR chain is 1.
    p_and_needs_or_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (|and_taps) |-> (&or_taps));
    // R1: a set MSB lands in the upper half of the index range.
    p_upper_half_r1: assert property (@(posedge clk) disable iff (!rst_n)
      code[V-1] |-> (idx >= IDXW'(V)));
  end else if (MODE == seg_p2s_pkg::FINE_HIGH) begin : g_high
    logic [V-1:0] and_taps;

    seg_prefix_chain #(.W(V), .TAPS(V), .SKIP(0), .OP(seg_p2s_pkg::CASC_AND))
      u_and (.code(code), .taps(and_taps));
    seg_ones_count #(.W(V), .OW(IDXW))
      u_cnt (.bits(and_taps), .count(idx));

    // R3: a clear MSB means no leading ones.
    p_msb_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !code[V-1] |-> (idx == '0));
  end else begin : g_low
    logic [V-1:0] or_taps;

    seg_prefix_chain #(.W(V), .TAPS(V), .SKIP(0), .OP(seg_p2s_pkg::CASC_OR))
      u_or (.code(code), .taps(or_taps));
    seg_ones_count #(.W(V), .OW(IDXW))
      u_cnt (.bits(or_taps), .count(idx));

    // R4: a set MSB means no leading zeros, so the index is V.
    p_msb_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      code[V-1] |-> (idx == IDXW'(V)));
  end
endmodule

// File: rtl/seg_out_reg.sv
// One-entry output register with valid/ready.
module seg_out_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  logic         full_q;
  logic [W-1:0] data_q;

  assign up_ready = !full_q || dn_ready;
  assign dn_valid = full_q;
  assign dn_data  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (up_ready) begin
      full_q <= up_valid;
      if (up_valid) data_q <= up_data;
    end
  end

  // R8: a stalled output holds its value.
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data)));
  // R8: nothing is taken while stalled.
  p_no_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |-> !up_ready);
  // R7: an accepted code is presented on the next cycle.
  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_ready) |=> (dn_valid && dn_data == $past(up_data)));
endmodule

// File: rtl/seg_p2s_encoder.sv
module seg_p2s_encoder #(
  parameter int                    V       = 5,
  parameter seg_p2s_pkg::seg_mode_e MODE    = seg_p2s_pkg::FINE_BOTH,
  parameter bit                    REG_OUT = 1'b1,
  parameter int                    IDXW    = seg_p2s_pkg::idx_width(V)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [V-1:0]    in_code,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [IDXW-1:0] out_idx
);
  localparam int MAX_IDX = (MODE == seg_p2s_pkg::FINE_BOTH) ? 2 * V - 1 : V;

  logic [IDXW-1:0] idx_c;

  seg_index_core #(.V(V), .MODE(MODE), .IDXW(IDXW)) u_core (
    .clk  (clk),
    .rst_n(rst_n),
    .code (in_code),
    .idx  (idx_c)
  );

  if (REG_OUT) begin : g_reg
    seg_out_reg #(.W(IDXW)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .up_valid(in_valid),
      .up_ready(in_ready),
      .up_data (idx_c),
      .dn_valid(out_valid),
      .dn_ready(out_ready),
      .dn_data (out_idx)
    );
  end else begin : g_comb
    assign out_valid = in_valid;
    assign in_ready  = out_ready;
    assign out_idx   = idx_c;
  end

  // R5: the index stays inside the mode's range.
  p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_idx <= IDXW'(MAX_IDX)));
endmodule

// File: tb/tb_seg_p2s_encoder.sv
module tb_seg_p2s_encoder;
  localparam int V    = 5;
  localparam int IDXW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // Registered, two-sided instance.
  logic            p_vld = 1'b0, p_rdy = 1'b0, p_irdy, p_ovld;
  logic [V-1:0]    p_code = '0;
  logic [IDXW-1:0] p_idx;
  // Shared stimulus for the unregistered instances.
  logic            c_vld = 1'b0, c_rdy = 1'b0;
  logic [V-1:0]    c_code = '0;
  logic            b_irdy, b_ovld, h_irdy, h_ovld, l_irdy, l_ovld;
  logic [IDXW-1:0] b_idx, h_idx, l_idx;

  seg_p2s_encoder #(.V(V), .MODE(seg_p2s_pkg::FINE_BOTH), .REG_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(p_vld), .in_ready(p_irdy), .in_code(p_code),
    .out_valid(p_ovld), .out_ready(p_rdy), .out_idx(p_idx));
  seg_p2s_encoder #(.V(V), .MODE(seg_p2s_pkg::FINE_BOTH), .REG_OUT(1'b0)) dut_b (
    .clk(clk), .rst_n(rst_n), .in_valid(c_vld), .in_ready(b_irdy), .in_code(c_code),
    .out_valid(b_ovld), .out_ready(c_rdy), .out_idx(b_idx));
  seg_p2s_encoder #(.V(V), .MODE(seg_p2s_pkg::FINE_HIGH), .REG_OUT(1'b0)) dut_h (
    .clk(clk), .rst_n(rst_n), .in_valid(c_vld), .in_ready(h_irdy), .in_code(c_code),
    .out_valid(h_ovld), .out_ready(c_rdy), .out_idx(h_idx));
  seg_p2s_encoder #(.V(V), .MODE(seg_p2s_pkg::FINE_LOW), .REG_OUT(1'b0)) dut_l (
    .clk(clk), .rst_n(rst_n), .in_valid(c_vld), .in_ready(l_irdy), .in_code(c_code),
    .out_valid(l_ovld), .out_ready(c_rdy), .out_idx(l_idx));

  // Reference model: 0 = both sides, 1 = leading ones, 2 = V - leading zeros.
  function automatic int model(input int mode, input logic [V-1:0] c);
    int lz = 0;
    int lo = 0;
    for (int i = V - 1; i >= 0 && c[i] == 1'b0; i--) lz++;
    for (int i = V - 1; i >= 0 && c[i] == 1'b1; i--) lo++;
    case (mode)
      1:       return lo;
      2:       return V - lz;
      default: return c[V-1] ? V + lo - 1 : V - lz;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    #1;
    chk(p_ovld == 1'b0, "R9 out_valid in reset", int'(p_ovld), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(p_ovld == 1'b0, "R9 out_valid after reset", int'(p_ovld), 0);
  endtask

  task automatic t_table_r2();
    logic [V-1:0] pats [10] = '{5'b00000, 5'b00001, 5'b00011, 5'b00110, 5'b01011,
                               5'b10101, 5'b11001, 5'b11100, 5'b11110, 5'b11111};
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      c_code = pats[j];
      #1;
      chk(b_idx == IDXW'(j), "R2 table entry", int'(b_idx), j);
    end
  endtask

  task automatic t_sweep_comb();
    for (int n = 0; n < (1 << V); n++) begin
      @(negedge clk);
      c_code = V'(n);
      #1;
      chk(int'(b_idx) == model(0, V'(n)), "R1 two-sided", int'(b_idx), model(0, V'(n)));
      chk(int'(h_idx) == model(1, V'(n)), "R3 high-only", int'(h_idx), model(1, V'(n)));
      chk(int'(l_idx) == model(2, V'(n)), "R4 low-only", int'(l_idx), model(2, V'(n)));
    end
  endtask

  task automatic t_width_r5();
    chk($bits(p_idx) == 4, "R5 index width", $bits(p_idx), 4);
    @(negedge clk);
    c_code = '1;
    #1;
    chk(b_idx == 4'd9, "R5 top index", int'(b_idx), 9);
  endtask

  task automatic t_pass_r6();
    @(negedge clk);
    c_vld = 1'b1; c_rdy = 1'b0; c_code = 5'b01000;
    #1;
    chk(b_ovld == 1'b1, "R6 valid passes", int'(b_ovld), 1);
    chk(b_irdy == 1'b0, "R6 ready passes low", int'(b_irdy), 0);
    chk(b_idx == 4'd4, "R6 same-cycle index", int'(b_idx), 4);
    c_vld = 1'b0; c_rdy = 1'b1;
    #1;
    chk(b_ovld == 1'b0, "R6 valid drops", int'(b_ovld), 0);
    chk(b_irdy == 1'b1, "R6 ready passes high", int'(b_irdy), 1);
  endtask

  task automatic t_stream_r7_r10();
    p_rdy = 1'b1;
    for (int n = 0; n <= (1 << V); n++) begin
      @(negedge clk);
      if (n > 0) begin
        chk(p_ovld == 1'b1, "R7 valid after accept", int'(p_ovld), 1);
        chk(int'(p_idx) == model(0, V'(n - 1)), "R7 registered index",
            int'(p_idx), model(0, V'(n - 1)));
        chk(p_irdy == 1'b1, "R10 ready while streaming", int'(p_irdy), 1);
      end
      if (n < (1 << V)) begin
        p_vld = 1'b1; p_code = V'(n);
      end else begin
        p_vld = 1'b0;
      end
    end
    @(negedge clk);
    chk(p_ovld == 1'b0, "R7 drained", int'(p_ovld), 0);
  endtask

  task automatic t_stall_r8();
    @(negedge clk);
    p_rdy = 1'b0; p_vld = 1'b1; p_code = 5'b00010;   // index 2
    @(negedge clk);
    chk(p_ovld == 1'b1 && p_idx == 4'd2, "R8 loaded", int'(p_idx), 2);
    p_code = 5'b11101;                                 // index 7, pending
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(p_irdy == 1'b0, "R8 ready low when stalled", int'(p_irdy), 0);
      @(negedge clk);
      chk(p_ovld == 1'b1 && p_idx == 4'd2, "R8 index holds", int'(p_idx), 2);
    end
    p_rdy = 1'b1;
    #1;
    chk(p_irdy == 1'b1, "R10 ready on drain", int'(p_irdy), 1);
    @(negedge clk);
    p_vld = 1'b0;
    chk(p_ovld == 1'b1 && p_idx == 4'd7, "R8 pending code follows", int'(p_idx), 7);
    @(negedge clk);
    chk(p_ovld == 1'b0, "R8 empty after drain", int'(p_ovld), 0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_table_r2();
    t_sweep_comb();
    t_width_r5();
    t_pass_r6();
    t_stream_r7_r10();
    t_stall_r8();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule